// File: doc/BRIEF.md
# Noise-Filtered Edge Interrupt Conditioner

This block turns one raw external pin into a clean interrupt request. The pin is first brought into the clock domain by a two-flop synchronizer. It then passes through a digital glitch filter. The filter samples the pin once every 2^k clocks, and k is set by a 3-bit select code. A filtered level changes only after eight consecutive samples agree on the new value, so short spikes never reach the edge logic.

The filtered level feeds an edge detector. The detector can fire on the rising edge only, on the falling edge only, or on both edges. Each accepted edge produces a one-clock interrupt pulse, provided the enable input is high. In both-edge mode, a flag records whether the interrupt came from the edge opposite to the one named by the edge-select input. Software reads that flag, and a read strobe clears it.

A select code of zero turns the filter off, and so does the low-speed-mode input. The synchronized pin is then used directly. Changing the select code restarts the sampling prescaler and the agreement counter.

Top module: `pin_irq_filter`

## Requirements
- R1: While reset is asserted, and right after it is released, `level_o`, `irq_o` and `edge_flag_o` are all 0.
- R2: With `nsel_i` = 000, the filter is bypassed. A pin change driven before clock edge N appears on `level_o` after edge N+2 and not before.
- R3: With `slow_mode_i` = 1, the filter is bypassed for any `nsel_i` value, with the same three-edge latency as R2.
- R4: A code n in 1..7 sets the sampling period T to 2^(n+5) clocks. The filtered level can change only on a sampling tick.
- R5: With the filter active, a pin pulse shorter than 7·T − 6 clocks never changes `level_o` and never raises `irq_o`.
- R6: With the filter active, a pin level held for at least 8·T + 5 clocks always reaches `level_o` by the end of that time.
- R7: With `both_edges_i` = 0, `edge_fall_i` = 0 selects rising edges of `level_o` and `edge_fall_i` = 1 selects falling edges. The other edge raises no interrupt.
- R8: With `both_edges_i` = 1, both rising and falling edges of `level_o` raise an interrupt.
- R9: `irq_o` is high for exactly one clock per accepted edge. It is high in the cycle after `level_o` changes, and only while `irq_en_i` = 1. A disabled edge produces no pulse and does not set the flag.
- R10: In both-edge mode, an interrupt from the edge opposite to `edge_fall_i` sets `edge_flag_o` to 1 on the next clock. An interrupt from the selected edge leaves the flag unchanged. Outside both-edge mode the flag is never set.
- R11: A high `flag_rd_i` clears `edge_flag_o` on the next clock. If a flag-setting interrupt happens in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw, asynchronous interrupt pin |
| nsel_i | input | 3 | Noise-filter select code (000 = filter off) |
| edge_fall_i | input | 1 | Edge select: 0 = rising, 1 = falling |
| both_edges_i | input | 1 | 1 = interrupt on both edges |
| irq_en_i | input | 1 | Interrupt enable |
| slow_mode_i | input | 1 | Low-speed mode; forces filter bypass |
| flag_rd_i | input | 1 | Status-read strobe; clears the edge flag |
| level_o | output | 1 | Filtered pin level |
| irq_o | output | 1 | One-clock interrupt request |
| edge_flag_o | output | 1 | 1 = last both-edge interrupt came from the non-selected edge |

## Verification
In bypass mode the timing is fixed:
- `level_o` follows the pin three clock edges after the change.
- `irq_o` is high in the cycle after that third edge.
- `edge_flag_o` updates one edge later.

The bench samples at the falling clock edge exactly at those points. With the filter active, the exact edge depends on the prescaler phase, so the bench does not check one cycle. Instead it pushes an expected edge into the scoreboard and lets the monitor pop it whenever the pulse arrives. It then checks that the queue has drained, and that `level_o` holds the right value, at the 8·T + 5 and 7·T − 6 boundaries of R5 and R6.

// File: rtl/pif_pkg.sv
package pif_pkg;

  // Default geometry of the block.
  parameter int unsigned SEL_W_DEF    = 3;
  parameter int unsigned EXP_BASE_DEF = 5;
  parameter int unsigned CONFIRM_DEF  = 8;
  parameter int unsigned SYNC_DEF     = 2;

  // Log2 of the sampling period for a select code.
  function automatic int unsigned sample_exp(input int unsigned code,
                                             input int unsigned base);
    return code + base;
  endfunction

  // True when the given edge is not the one named by edge select.
  function automatic logic is_opposite(input logic rising, input logic sel_fall);
    return rising ? sel_fall : !sel_fall;
  endfunction

endpackage

// File: rtl/pif_sync.sv
module pif_sync #(
  parameter int unsigned STAGES = pif_pkg::SYNC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pif_prescaler.sv
module pif_prescaler #(
  parameter int unsigned SEL_W    = pif_pkg::SEL_W_DEF,
  parameter int unsigned EXP_BASE = pif_pkg::EXP_BASE_DEF,
  localparam int unsigned CW      = (1 << SEL_W) - 1 + EXP_BASE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] code_i,
  input  logic             restart_i,
  output logic             tick_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  // A full-width shift wraps to zero, and subtracting one then gives all ones.
  always_comb
    limit = (CW'(1) << pif_pkg::sample_exp(int'(code_i), EXP_BASE)) - CW'(1);

  assign tick_o = (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/pif_filter.sv
module pif_filter #(
  parameter int unsigned CONFIRM = pif_pkg::CONFIRM_DEF,
  localparam int unsigned RW     = $clog2(CONFIRM)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic tick_i,
  input  logic restart_i,
  input  logic bypass_i,
  output logic level_o
);

  logic [RW-1:0] run_q;
  logic          level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      run_q   <= '0;
    end else if (bypass_i) begin
      level_q <= sample_i;
      run_q   <= '0;
    end else if (restart_i) begin
      run_q   <= '0;
    end else if (tick_i) begin
      if (sample_i == level_q) begin
        run_q <= '0;
      end else if (run_q == RW'(CONFIRM - 1)) begin
        level_q <= sample_i;
        run_q   <= '0;
      end else begin
        run_q <= run_q + RW'(1);
      end
    end
  end

  assign level_o = level_q;

endmodule

// File: rtl/pif_edge.sv
module pif_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic en_i,
  input  logic sel_fall_i,
  input  logic both_i,
  input  logic rd_i,
  output logic rise_ev_o,
  output logic fall_ev_o,
  output logic flag_set_o,
  output logic irq_o,
  output logic flag_o
);

  logic level_d_q;
  logic flag_q;
  logic hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_d_q <= 1'b0;
    else         level_d_q <= level_i;
  end

  assign rise_ev_o = level_i & ~level_d_q;
  assign fall_ev_o = ~level_i & level_d_q;

  always_comb begin
    if (both_i)          hit = rise_ev_o | fall_ev_o;
    else if (sel_fall_i) hit = fall_ev_o;
    else                 hit = rise_ev_o;
  end

  assign irq_o      = en_i & hit;
  assign flag_set_o = irq_o & both_i & pif_pkg::is_opposite(rise_ev_o, sel_fall_i);

  // A new flag-setting event takes priority over a read in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (flag_set_o) flag_q <= 1'b1;
    else if (rd_i)       flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/pin_irq_filter.sv
module pin_irq_filter #(
  parameter int unsigned SEL_W    = pif_pkg::SEL_W_DEF,
  parameter int unsigned EXP_BASE = pif_pkg::EXP_BASE_DEF,
  parameter int unsigned CONFIRM  = pif_pkg::CONFIRM_DEF,
  parameter int unsigned SYNC     = pif_pkg::SYNC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [SEL_W-1:0] nsel_i,
  input  logic             edge_fall_i,
  input  logic             both_edges_i,
  input  logic             irq_en_i,
  input  logic             slow_mode_i,
  input  logic             flag_rd_i,
  output logic             level_o,
  output logic             irq_o,
  output logic             edge_flag_o
);

  logic             pin_sync;
  logic             tick;
  logic             restart;
  logic             bypass;
  logic             rise_ev;
  logic             fall_ev;
  logic             flag_set;
  logic [SEL_W-1:0] nsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nsel_q <= '0;
    else         nsel_q <= nsel_i;
  end

  assign restart = (nsel_i != nsel_q);
  assign bypass  = (nsel_i == '0) | slow_mode_i;

  pif_sync #(.STAGES(SYNC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  pif_prescaler #(.SEL_W(SEL_W), .EXP_BASE(EXP_BASE)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_i    (nsel_i),
    .restart_i (restart | bypass),
    .tick_o    (tick)
  );

  pif_filter #(.CONFIRM(CONFIRM)) u_filt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (pin_sync),
    .tick_i    (tick),
    .restart_i (restart),
    .bypass_i  (bypass),
    .level_o   (level_o)
  );

  pif_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (level_o),
    .en_i       (irq_en_i),
    .sel_fall_i (edge_fall_i),
    .both_i     (both_edges_i),
    .rd_i       (flag_rd_i),
    .rise_ev_o  (rise_ev),
    .fall_ev_o  (fall_ev),
    .flag_set_o (flag_set),
    .irq_o      (irq_o),
    .flag_o     (edge_flag_o)
  );

endmodule

// File: rtl/pif_checker.sv
module pif_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic pin_sync,
  input logic bypass,
  input logic restart,
  input logic tick,
  input logic irq_o,
  input logic irq_en_i,
  input logic level_o,
  input logic edge_flag_o,
  input logic flag_rd_i,
  input logic flag_set,
  input logic both_edges_i,
  input logic edge_fall_i,
  input logic rise_ev,
  input logic fall_ev
);

  // R9: the request never lasts two cycles
  assert_irq_one_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R9: no request while disabled
  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_i);

  // R2 and R3: in bypass, the level copies the synchronized pin
  assert_bypass_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass |=> (level_o == $past(pin_sync)));

  // R4: with the filter active, the level moves only on a sampling tick
  assert_level_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass && !restart && !tick) |=> $stable(level_o));

  // R7: a single-edge request matches the selected direction
  assert_single_dir_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !both_edges_i) |-> (edge_fall_i ? fall_ev : rise_ev));

  // R10: the flag is set only by a both-edge request
  assert_flag_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(edge_flag_o) |-> $past(irq_o && both_edges_i));

  // R11: a read without a competing set clears the flag
  assert_flag_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_rd_i && !flag_set) |=> !edge_flag_o);

endmodule

bind pin_irq_filter pif_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pin_sync     (pin_sync),
  .bypass       (bypass),
  .restart      (restart),
  .tick         (tick),
  .irq_o        (irq_o),
  .irq_en_i     (irq_en_i),
  .level_o      (level_o),
  .edge_flag_o  (edge_flag_o),
  .flag_rd_i    (flag_rd_i),
  .flag_set     (flag_set),
  .both_edges_i (both_edges_i),
  .edge_fall_i  (edge_fall_i),
  .rise_ev      (rise_ev),
  .fall_ev      (fall_ev)
);

// File: tb/pin_irq_filter_test.sv
module pin_irq_filter_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin;
  logic [2:0] nsel;
  logic       sel_fall, both, en, slow, rd;
  logic       level, irq, flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct packed { logic rise; logic flag; } item_t;
  item_t sb[$];

  logic model_level = 1'b0;
  logic model_flag  = 1'b0;
  logic flag_due    = 1'b0;
  logic flag_exp    = 1'b0;

  always #5 clk = ~clk;

  pin_irq_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .nsel_i(nsel),
    .edge_fall_i(sel_fall), .both_edges_i(both), .irq_en_i(en),
    .slow_mode_i(slow), .flag_rd_i(rd), .level_o(level),
    .irq_o(irq), .edge_flag_o(flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endfunction

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cycles);
      summary();
      $finish;
    end
  end

  // Monitor: pops the scoreboard whenever a pulse appears
  always @(negedge clk) begin
    if (flag_due) begin
      check(flag == flag_exp, "R10 flag after irq", flag, flag_exp);
      flag_due = 1'b0;
    end
    if (rst_n && irq) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected irq", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(level == it.rise, "R7/R8 irq edge direction", level, it.rise);
        flag_exp = it.flag;
        flag_due = 1'b1;
      end
    end
  end

  // Driver: change the pin and predict the resulting request
  task automatic apply(input logic v, input bit accepted);
    @(negedge clk);
    pin = v;
    if (accepted && v != model_level) begin
      model_level = v;
      if (en && (both || (sel_fall ? !v : v))) begin
        if (both && (v ? sel_fall : !sel_fall)) model_flag = 1'b1;
        sb.push_back('{rise: v, flag: model_flag});
      end
    end
  endtask

  task automatic seg(input logic v, input int hold, input bit accepted);
    apply(v, accepted);
    repeat (hold) @(negedge clk);
  endtask

  task automatic drain(input int waitc, input string req);
    repeat (waitc) @(negedge clk);
    check(sb.size() == 0, req, sb.size(), 0);
  endtask

  // Bypass latency: unchanged after two edges, changed after three
  task automatic latency(input logic v, input string req);
    logic old;
    old = level;
    apply(v, 1'b1);
    repeat (2) @(negedge clk);
    check(level == old, req, level, old);
    @(negedge clk);
    check(level == v, req, level, v);
  endtask

  task automatic read_flag();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    model_flag = 1'b0;
    check(flag == 1'b0, "R11 read clears flag", flag, 0);
  endtask

  initial begin
    rst_n = 1'b0; pin = 1'b0; nsel = 3'd0; sel_fall = 1'b0; both = 1'b0;
    en = 1'b1; slow = 1'b0; rd = 1'b0;
    repeat (3) @(negedge clk);
    check(level == 0 && irq == 0 && flag == 0, "R1 reset outputs", {level, irq, flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(level == 0 && irq == 0 && flag == 0, "R1 after release", {level, irq, flag}, 0);

    // R2 / R7: rising edge only
    latency(1'b1, "R2 bypass latency");
    seg(1'b1, 8, 1'b1);
    seg(1'b0, 10, 1'b1);
    drain(4, "R7 rising only");

    // R7: falling edge only
    sel_fall = 1'b1;
    seg(1'b1, 10, 1'b1);
    seg(1'b0, 10, 1'b1);
    drain(4, "R7 falling only");

    // R8 / R10: both edges, rising selected
    both = 1'b1; sel_fall = 1'b0;
    seg(1'b1, 10, 1'b1);
    check(flag == 0, "R10 selected edge leaves flag", flag, 0);
    seg(1'b0, 10, 1'b1);
    check(flag == 1, "R10 opposite edge sets flag", flag, 1);
    drain(2, "R8 both edges");
    read_flag();

    // R11: read and set in the same cycle, set wins
    seg(1'b1, 10, 1'b1);
    apply(1'b0, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    check(flag == 1, "R11 set wins over read", flag, 1);
    read_flag();

    // R10: falling selected, rising is the opposite edge
    sel_fall = 1'b1;
    seg(1'b1, 10, 1'b1);
    check(flag == 1, "R10 rising is opposite", flag, 1);
    read_flag();
    seg(1'b0, 10, 1'b1);
    check(flag == 0, "R10 falling is selected", flag, 0);
    drain(2, "R8 both edges falling sel");

    // R9: disabled edges make no pulse and no flag
    en = 1'b0;
    seg(1'b1, 10, 1'b1);
    seg(1'b0, 10, 1'b1);
    drain(2, "R9 disabled no irq");
    check(flag == 0, "R9 disabled leaves flag", flag, 0);
    en = 1'b1;

    // R3: low-speed mode bypasses a nonzero code
    sel_fall = 1'b0;
    slow = 1'b1; nsel = 3'd1;
    latency(1'b1, "R3 slow-mode bypass");
    seg(1'b1, 8, 1'b1);
    seg(1'b0, 10, 1'b1);
    drain(2, "R3 slow-mode edges");
    read_flag();
    slow = 1'b0;

    // R5 / R6 with T = 64
    seg(1'b0, 20, 1'b1);
    seg(1'b1, 7 * 64 - 7, 1'b0);
    seg(1'b0, 9 * 64 + 10, 1'b0);
    check(level == 0, "R5 short pulse rejected T=64", level, 0);
    drain(1, "R5 no irq T=64");
    seg(1'b1, 8 * 64 + 5, 1'b1);
    check(level == 1, "R6 long high accepted T=64", level, 1);
    seg(1'b0, 8 * 64 + 5, 1'b1);
    check(level == 0, "R6 long low accepted T=64", level, 0);
    drain(10, "R6 irqs T=64");
    read_flag();

    // R4 / R5 with T = 256
    nsel = 3'd3;
    seg(1'b1, 7 * 256 - 7, 1'b0);
    seg(1'b0, 9 * 256 + 10, 1'b0);
    check(level == 0, "R4/R5 short pulse rejected T=256", level, 0);
    drain(1, "R5 no irq T=256");

    // R4 / R6 with T = 4096
    nsel = 3'd7;
    seg(1'b1, 8 * 4096 + 5, 1'b1);
    check(level == 1, "R4/R6 long high accepted T=4096", level, 1);
    seg(1'b0, 8 * 4096 + 5, 1'b1);
    check(level == 0, "R4/R6 long low accepted T=4096", level, 0);
    drain(10, "R6 irqs T=4096");

    summary();
    $finish;
  end

endmodule